// File: doc/BRIEF.md
# Bus Cycle Address Decoder and Reply Generator

This block is the slave-side control logic for an asynchronous, multiplexed address/data bus. When the active-low sync strobe first goes low, the block captures the three low address bits and a device-enable input. It then holds one of four active-low word-register selects for the rest of the bus cycle. It turns the data-out strobe, the write/byte qualifier and the captured byte address into separate low-byte and high-byte write strobes. It turns the data-in strobe into a word read strobe.

A reply output answers each data strobe after a programmable number of clock cycles. A cycle counter provides this delay. The counter can be reloaded at run time and comes out of reset at four cycles. An interrupt-vector request produces the same delayed reply without any bus cycle in progress. All bus inputs are treated as synchronous to `clk`. Every output is registered.

Top module: `bus_slave_decoder`

## Requirements
- R1: The address bits `dal` and `dev_en` are captured at the first clock edge that samples `sync_n` low. Later changes to either input have no effect until `sync_n` has been sampled high.
- R2: At that first edge, `sel_n[k]` goes low for k = `dal[2:1]` and the other selects stay high. This happens only if `dev_en` is high at that edge. With `dev_en` low, all four selects stay high for the whole cycle.
- R3: A select, once low, does not change while `sync_n` stays low. All selects are high after the first edge that samples `sync_n` high.
- R4: The write strobes go low at an edge that samples `dout_n` low while a sync cycle is active (sync was captured at an earlier edge). If `wtbt_n` is 1 (word), both `wr_lo_n` and `wr_hi_n` go low. If `wtbt_n` is 0 (byte), captured address bit 0 = 0 drives only `wr_lo_n` low, and bit 0 = 1 drives only `wr_hi_n` low.
- R5: `rd_word_n` goes low at an edge that samples `din_n` low while a sync cycle is active. The captured enable does not gate it.
- R6: `reply_n` goes low at the N-th consecutive edge that samples the reply trigger active. N comes out of reset as 4. It is reloaded from `dly_val` at an edge with `dly_load` high, and a loaded 0 acts as 1.
- R7: `reply_n` returns high at the first edge that samples the trigger inactive.
- R8: `vec_req` high is a reply trigger on its own, whatever the state of `sync_n` and `dev_en`.
- R9: While `sync_n` is sampled high, the selects and all three strobes are high, and `din_n`/`dout_n` do not trigger a reply.
- R10: `din_n` or `dout_n` triggers a reply only if the enable captured at the sync edge was high.
- R11: `reply_stat` is always the inverse of `reply_n`.
- R12: After synchronous reset, all active-low outputs are high and `reply_stat` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sync_n | input | 1 | Bus cycle sync strobe, active low |
| dal | input | 3 | Low address bits; [2:1] pick the register, [0] picks the byte |
| dev_en | input | 1 | Device enable, captured at the sync edge |
| wtbt_n | input | 1 | 0 = byte write, 1 = word write |
| dout_n | input | 1 | Data-out (write) strobe, active low |
| din_n | input | 1 | Data-in (read) strobe, active low |
| vec_req | input | 1 | Vector request; triggers a reply without a bus cycle |
| dly_load | input | 1 | Load the reply delay from dly_val |
| dly_val | input | 4 | New reply delay in cycles (0 acts as 1) |
| sel_n | output | 4 | Word-register selects, active low |
| wr_lo_n | output | 1 | Low-byte write strobe, active low |
| wr_hi_n | output | 1 | High-byte write strobe, active low |
| rd_word_n | output | 1 | Word read strobe, active low |
| reply_n | output | 1 | Delayed reply, active low |
| reply_stat | output | 1 | Inverted copy of reply_n |

## Verification
The checker watches several properties on every clock edge:
- At most one select is low, and the selects hold steady while sync stays low.
- Selects and strobes go inactive after sync is sampled high.
- Each write or read strobe is traced back to the strobe input, and the word/byte qualifier, sampled one edge before.
- The reply drops once no trigger is present, and the status output mirrors the reply.

Some behaviours only the bench scenarios can show:
- the exact select decoded for each address;
- that a changed address or enable is ignored once captured;
- the exact cycle count of the delay before reply, including after a reload;
- that a vector request replies with no bus cycle in progress.

// File: rtl/bsd_pkg.sv
package bsd_pkg;
  // Clamp a programmed delay so that zero behaves as a single cycle.
  function automatic logic [7:0] clamp_delay(input logic [7:0] v);
    return (v == 8'd0) ? 8'd1 : v;
  endfunction
endpackage

// File: rtl/bsd_addr_latch.sv
module bsd_addr_latch #(
  parameter int SEL_BITS = 2,
  localparam int NSEL = 1 << SEL_BITS,
  localparam int AW = SEL_BITS + 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sync_n,
  input  logic [AW-1:0]   dal,
  input  logic            dev_en,
  output logic            act,
  output logic [AW-1:0]   addr_l,
  output logic            en_l,
  output logic [NSEL-1:0] sel_n
);
  logic [NSEL-1:0] dec;

  always_comb begin
    dec = '1;
    for (int k = 0; k < NSEL; k++)
      if (dal[AW-1:1] == SEL_BITS'(k)) dec[k] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act    <= 1'b0;
      addr_l <= '0;
      en_l   <= 1'b0;
      sel_n  <= '1;
    end else if (sync_n) begin
      act   <= 1'b0;
      sel_n <= '1;
    end else if (!act) begin
      act    <= 1'b1;
      addr_l <= dal;
      en_l   <= dev_en;
      sel_n  <= dev_en ? dec : '1;
    end
  end
endmodule

// File: rtl/bsd_strobes.sv
module bsd_strobes (
  input  logic clk,
  input  logic rst,
  input  logic live,
  input  logic byte_sel,
  input  logic wtbt_n,
  input  logic dout_n,
  input  logic din_n,
  output logic wr_lo_n,
  output logic wr_hi_n,
  output logic rd_word_n
);
  logic wr_any, lo_hit, hi_hit;

  assign wr_any = live & ~dout_n;
  assign lo_hit = wr_any & (wtbt_n | ~byte_sel);
  assign hi_hit = wr_any & (wtbt_n | byte_sel);

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_lo_n   <= 1'b1;
      wr_hi_n   <= 1'b1;
      rd_word_n <= 1'b1;
    end else begin
      wr_lo_n   <= ~lo_hit;
      wr_hi_n   <= ~hi_hit;
      rd_word_n <= ~(live & ~din_n);
    end
  end
endmodule

// File: rtl/bsd_reply_timer.sv
module bsd_reply_timer #(
  parameter int DLY_W = 4,
  parameter int DLY_DEFAULT = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             trig,
  input  logic             dly_load,
  input  logic [DLY_W-1:0] dly_val,
  output logic             rep
);
  import bsd_pkg::*;

  logic [DLY_W-1:0] lim_q;
  logic [DLY_W-1:0] cnt;
  logic [DLY_W-1:0] lim_clamped;

  assign lim_clamped = DLY_W'(clamp_delay(8'(dly_val)));

  always_ff @(posedge clk) begin
    if (rst) lim_q <= DLY_W'(DLY_DEFAULT);
    else if (dly_load) lim_q <= lim_clamped;
  end

  always_ff @(posedge clk) begin
    if (rst || !trig) begin
      cnt <= '0;
      rep <= 1'b0;
    end else if (cnt == lim_q - DLY_W'(1)) begin
      rep <= 1'b1;
    end else begin
      cnt <= cnt + DLY_W'(1);
    end
  end
endmodule

// File: rtl/bus_slave_decoder.sv
module bus_slave_decoder #(
  parameter int SEL_BITS = 2,
  parameter int DLY_W = 4,
  parameter int DLY_DEFAULT = 4,
  localparam int NSEL = 1 << SEL_BITS,
  localparam int AW = SEL_BITS + 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sync_n,
  input  logic [AW-1:0]   dal,
  input  logic            dev_en,
  input  logic            wtbt_n,
  input  logic            dout_n,
  input  logic            din_n,
  input  logic            vec_req,
  input  logic            dly_load,
  input  logic [DLY_W-1:0] dly_val,
  output logic [NSEL-1:0] sel_n,
  output logic            wr_lo_n,
  output logic            wr_hi_n,
  output logic            rd_word_n,
  output logic            reply_n,
  output logic            reply_stat
);
  logic          act, en_l, live, trig, rep;
  logic [AW-1:0] addr_l;

  bsd_addr_latch #(.SEL_BITS(SEL_BITS)) u_latch (
    .clk(clk), .rst(rst), .sync_n(sync_n), .dal(dal), .dev_en(dev_en),
    .act(act), .addr_l(addr_l), .en_l(en_l), .sel_n(sel_n)
  );

  // A cycle is live once sync was captured at an earlier edge and is still held.
  assign live = act & ~sync_n;

  bsd_strobes u_strobes (
    .clk(clk), .rst(rst), .live(live), .byte_sel(addr_l[0]),
    .wtbt_n(wtbt_n), .dout_n(dout_n), .din_n(din_n),
    .wr_lo_n(wr_lo_n), .wr_hi_n(wr_hi_n), .rd_word_n(rd_word_n)
  );

  assign trig = vec_req | (live & en_l & (~din_n | ~dout_n));

  bsd_reply_timer #(.DLY_W(DLY_W), .DLY_DEFAULT(DLY_DEFAULT)) u_timer (
    .clk(clk), .rst(rst), .trig(trig), .dly_load(dly_load),
    .dly_val(dly_val), .rep(rep)
  );

  assign reply_n    = ~rep;
  assign reply_stat = rep;
endmodule

// File: rtl/bus_slave_decoder_chk.sv
module bus_slave_decoder_chk #(
  parameter int NSEL = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            sync_n,
  input logic            wtbt_n,
  input logic            dout_n,
  input logic            din_n,
  input logic            vec_req,
  input logic [NSEL-1:0] sel_n,
  input logic            wr_lo_n,
  input logic            wr_hi_n,
  input logic            rd_word_n,
  input logic            reply_n,
  input logic            reply_stat
);
  a_r2_one_select: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~sel_n));

  a_r3_select_hold: assert property (@(posedge clk) disable iff (rst)
    (!sync_n && $past(!sync_n)) |=> $stable(sel_n));

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    sync_n |=> (sel_n == '1 && wr_lo_n && wr_hi_n && rd_word_n));

  a_r4_write_source: assert property (@(posedge clk) disable iff (rst)
    (!wr_lo_n || !wr_hi_n) |-> $past(!dout_n && !sync_n));

  a_r4_word_both: assert property (@(posedge clk) disable iff (rst)
    (!wr_lo_n && !wr_hi_n) |-> $past(wtbt_n));

  a_r5_read_source: assert property (@(posedge clk) disable iff (rst)
    !rd_word_n |-> $past(!din_n && !sync_n));

  a_r7_reply_drop: assert property (@(posedge clk) disable iff (rst)
    (!vec_req && din_n && dout_n) |=> reply_n);

  a_r11_status_mirror: assert property (@(posedge clk) disable iff (rst)
    reply_stat != reply_n);
endmodule

bind bus_slave_decoder bus_slave_decoder_chk #(.NSEL(NSEL)) u_chk (
  .clk(clk), .rst(rst), .sync_n(sync_n), .wtbt_n(wtbt_n), .dout_n(dout_n),
  .din_n(din_n), .vec_req(vec_req), .sel_n(sel_n), .wr_lo_n(wr_lo_n),
  .wr_hi_n(wr_hi_n), .rd_word_n(rd_word_n), .reply_n(reply_n),
  .reply_stat(reply_stat)
);

// File: tb/bus_slave_decoder_test.sv
module bus_slave_decoder_test;
  localparam int PERIOD = 10;
  localparam int NROWS = 8;
  // Row layout: dal[13:11] en[10] wtbt_n[9] is_write[8] exp_sel_n[7:4]
  //             exp_lo_n[3] exp_hi_n[2] exp_rd_n[1] exp_reply[0]
  localparam logic [13:0] VEC [NROWS] = '{
    14'b000_1_1_0_1110_1_1_0_1,
    14'b010_1_1_1_1101_0_0_1_1,
    14'b100_1_0_1_1011_0_1_1_1,
    14'b111_1_0_1_0111_1_0_1_1,
    14'b011_0_1_0_1111_1_1_0_0,
    14'b101_0_0_1_1111_1_0_1_0,
    14'b110_1_1_0_0111_1_1_0_1,
    14'b001_1_0_1_1110_1_0_1_1
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sync_n = 1'b1, dev_en = 1'b0, wtbt_n = 1'b1;
  logic dout_n = 1'b1, din_n = 1'b1, vec_req = 1'b0, dly_load = 1'b0;
  logic [2:0] dal = '0;
  logic [3:0] dly_val = '0;
  logic [3:0] sel_n;
  logic wr_lo_n, wr_hi_n, rd_word_n, reply_n, reply_stat;
  int checks = 0, errors = 0;

  always #(PERIOD/2) clk = ~clk;

  bus_slave_decoder uut (
    .clk(clk), .rst(rst), .sync_n(sync_n), .dal(dal), .dev_en(dev_en),
    .wtbt_n(wtbt_n), .dout_n(dout_n), .din_n(din_n), .vec_req(vec_req),
    .dly_load(dly_load), .dly_val(dly_val), .sel_n(sel_n),
    .wr_lo_n(wr_lo_n), .wr_hi_n(wr_hi_n), .rd_word_n(rd_word_n),
    .reply_n(reply_n), .reply_stat(reply_stat)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Counts edges from the first one sampling a trigger until reply_n is low; 0 = none in 10.
  task automatic edges_to_reply(output int n);
    n = 0;
    for (int i = 1; i <= 10; i++) begin
      @(posedge clk); #1;
      if (!reply_n && n == 0) n = i;
    end
  endtask

  task automatic load_delay(input logic [3:0] v);
    @(negedge clk); dly_load = 1'b1; dly_val = v;
    @(negedge clk); dly_load = 1'b0;
  endtask

  initial begin
    #(PERIOD * 200000);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(posedge clk);
    #1;
    check("R12 sel", 32'(sel_n), 32'hF);
    check("R12 strobes", {wr_lo_n, wr_hi_n, rd_word_n, reply_n}, 4'hF);
    check("R12 stat", 32'(reply_stat), 0);
    @(negedge clk); rst = 1'b0;

    for (int r = 0; r < NROWS; r++) begin
      logic [13:0] v;
      v = VEC[r];
      @(negedge clk); sync_n = 1'b0; dal = v[13:11]; dev_en = v[10];
      @(posedge clk); #1;
      check($sformatf("R2 row%0d sel", r), 32'(sel_n), 32'(v[7:4]));
      @(negedge clk);
      dal = ~v[13:11]; dev_en = ~v[10]; wtbt_n = v[9];
      if (v[8]) dout_n = 1'b0; else din_n = 1'b0;
      @(posedge clk); #1;
      check($sformatf("R4 row%0d lo/hi", r), {wr_lo_n, wr_hi_n}, {v[3], v[2]});
      check($sformatf("R5 row%0d rd", r), 32'(rd_word_n), 32'(v[1]));
      check($sformatf("R1 row%0d sel after input change", r), 32'(sel_n), 32'(v[7:4]));
      edges_to_reply(n);
      check($sformatf("R6 R10 row%0d reply edge", r), n, v[0] ? 4 - 1 : 0);
      @(negedge clk); dout_n = 1'b1; din_n = 1'b1;
      @(posedge clk); #1;
      check($sformatf("R7 row%0d reply clear", r), {reply_n, reply_stat}, 2'b10);
      check($sformatf("R3 row%0d sel held", r), 32'(sel_n), 32'(v[7:4]));
      @(negedge clk); sync_n = 1'b1;
      @(posedge clk); #1;
      check($sformatf("R3 row%0d sel released", r), 32'(sel_n), 32'hF);
    end
    // In the loop the first counted edge was already consumed by the strobe check,
    // so a 4-edge delay reads as 3 there.

    // R8: vector request with the bus idle
    @(negedge clk); vec_req = 1'b1;
    edges_to_reply(n);
    check("R8 vector reply edge", n, 4);
    check("R11 status mirrors reply", {reply_n, reply_stat}, 2'b01);
    check("R9 sel idle during vector", 32'(sel_n), 32'hF);
    @(negedge clk); vec_req = 1'b0;
    @(posedge clk); #1;
    check("R7 vector clear", 32'(reply_n), 1);

    // R9: data strobes with sync idle
    @(negedge clk); din_n = 1'b0; dout_n = 1'b0; wtbt_n = 1'b1;
    edges_to_reply(n);
    check("R9 no reply without sync", n, 0);
    check("R9 strobes idle", {wr_lo_n, wr_hi_n, rd_word_n}, 3'b111);
    @(negedge clk); din_n = 1'b1; dout_n = 1'b1;

    // R8: vector during a disabled cycle
    @(negedge clk); sync_n = 1'b0; dev_en = 1'b0; dal = 3'b010;
    @(negedge clk); vec_req = 1'b1;
    edges_to_reply(n);
    check("R8 vector ignores enable", n, 4);
    @(negedge clk); vec_req = 1'b0; sync_n = 1'b1;
    @(posedge clk); #1;

    // R6: reload the delay
    load_delay(4'd2);
    @(negedge clk); vec_req = 1'b1;
    edges_to_reply(n);
    check("R6 delay 2", n, 2);
    @(negedge clk); vec_req = 1'b0;
    load_delay(4'd0);
    @(negedge clk); vec_req = 1'b1;
    edges_to_reply(n);
    check("R6 delay 0 acts as 1", n, 1);
    @(negedge clk); vec_req = 1'b0;
    load_delay(4'd7);
    @(negedge clk); vec_req = 1'b1;
    edges_to_reply(n);
    check("R6 delay 7", n, 7);
    @(negedge clk); vec_req = 1'b0;

    // R12: reset mid-cycle clears everything
    @(negedge clk); sync_n = 1'b0; dev_en = 1'b1; dal = 3'b100; vec_req = 1'b1;
    repeat (8) @(posedge clk);
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1;
    check("R12 reset mid-cycle", {sel_n, reply_n, reply_stat}, 6'b111110);
    @(negedge clk); rst = 1'b0; vec_req = 1'b0; sync_n = 1'b1;
    @(negedge clk); vec_req = 1'b1;
    edges_to_reply(n);
    check("R12 delay back to default", n, 4);
    @(negedge clk); vec_req = 1'b0;

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule